// File: doc/BRIEF.md
# Feed Engine Interrupt and FIFO Status Unit

This unit sits beside the data-feed engine of a crypto accelerator and tells software when any of four transfer channels has finished a piece of work. Each channel raises a one-cycle completion pulse. The unit latches that pulse into a raw event word. Software holds a per-channel enable mask, and a single level interrupt line reports whether any latched event is also enabled.

Software reaches the unit through a small 32-bit register port. The mask cannot be written directly. One offset turns bits on where ones are written, and another turns bits off. To acknowledge an interrupt, software reads the raw word and writes that value back to the acknowledge offset, which clears exactly the events it has seen. The acknowledge offset also gives a masked read-back of pending events. A fifth, read-only word gathers the full and empty flags of the four channel FIFOs so that one read shows the state of all of them.

The channel order is fixed: bit 3 is block receive, bit 2 is block transmit, bit 1 is hash receive and bit 0 is public key.

Top module: `feed_irq_unit`

## Requirements
- R1: An active-low reset clears the raw event word, the enable mask and `irq_o` to zero.
- R2: A high `event_i[i]` sets raw bit i at the next clock edge, whatever the mask holds. The raw word reads at offset 0x00 in bits 3:0, with block receive=3, block transmit=2, hash receive=1 and public key=0.
- R3: A write to offset 0x04 sets every mask bit whose `bus_wdata` bit (3:0) is one. Zero bits and `bus_wdata` bits above 3 leave the mask unchanged.
- R4: A write to offset 0x08 clears every mask bit whose `bus_wdata` bit (3:0) is one. Zero bits leave the mask unchanged.
- R5: Reads at offset 0x04 or 0x08 return the mask in bits 3:0. A read at offset 0x0C returns the raw word ANDed with the mask. All upper bits read as zero.
- R6: A write to offset 0x0C clears every raw bit whose `bus_wdata` bit is one. Raw bits written with zero are kept.
- R7: When an event arrives in the same cycle as an acknowledge of its bit, the bit stays set.
- R8: `irq_o` is a register that holds the OR of (raw AND mask), so it follows a change of either word one clock later. A raw bit that is masked never raises it.
- R9: A read at offset 0x10 returns the FIFO flags as bit 2i+1 = `fifo_full_i[i]` and bit 2i = `fifo_empty_i[i]`, with bits 31:8 zero.
- R10: Writes to offsets 0x00 and 0x10 change no state, and a read at any unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data (combinational from the address) |
| event_i | input | NUM_SRC (4) | Per-channel completion pulses |
| fifo_full_i | input | NUM_SRC (4) | Per-channel FIFO full flags |
| fifo_empty_i | input | NUM_SRC (4) | Per-channel FIFO empty flags |
| irq_o | output | 1 | Level interrupt request |

## Verification
If a raw bit is latched wrongly or lost, the error shows at the very next read of offset 0x00. It also shows one cycle later on `irq_o`, provided that channel is enabled. A mask bit that is stuck or flipped shows at once on a read of 0x04 or 0x08, and in the masked pending read. The hardest case is the race between an event and its own acknowledge, because getting it wrong loses an interrupt without any other sign. The bench therefore sets up that race directly and reads the raw word in the cycle after it.

// File: rtl/feed_irq_pkg.sv
package feed_irq_pkg;

    // Register offsets (byte addresses)
    localparam logic [7:0] OFS_RAW   = 8'h00;
    localparam logic [7:0] OFS_ENSET = 8'h04;
    localparam logic [7:0] OFS_ENCLR = 8'h08;
    localparam logic [7:0] OFS_ACK   = 8'h0C;
    localparam logic [7:0] OFS_FIFO  = 8'h10;

    typedef enum logic [2:0] {
        RD_NONE,
        RD_RAW,
        RD_MASK,
        RD_PEND,
        RD_FIFO
    } rd_sel_t;

    typedef struct packed {
        logic mask_set;
        logic mask_clr;
        logic ack;
    } wr_stb_t;

endpackage

// File: rtl/feed_irq_decode.sv
module feed_irq_decode
    import feed_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output wr_stb_t           wr_stb,
    output rd_sel_t           rd_sel
);

    logic hit_raw, hit_set, hit_clr, hit_ack, hit_fifo;

    always_comb begin
        hit_raw  = (bus_addr == ADDR_W'(OFS_RAW));
        hit_set  = (bus_addr == ADDR_W'(OFS_ENSET));
        hit_clr  = (bus_addr == ADDR_W'(OFS_ENCLR));
        hit_ack  = (bus_addr == ADDR_W'(OFS_ACK));
        hit_fifo = (bus_addr == ADDR_W'(OFS_FIFO));

        wr_stb.mask_set = bus_sel && bus_wr && hit_set;
        wr_stb.mask_clr = bus_sel && bus_wr && hit_clr;
        wr_stb.ack      = bus_sel && bus_wr && hit_ack;

        if (hit_raw)                  rd_sel = RD_RAW;
        else if (hit_set || hit_clr)  rd_sel = RD_MASK;
        else if (hit_ack)             rd_sel = RD_PEND;
        else if (hit_fifo)            rd_sel = RD_FIFO;
        else                          rd_sel = RD_NONE;
    end

endmodule

// File: rtl/feed_irq_latch.sv
module feed_irq_latch #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] event_i,
    input  logic               ack_stb,
    input  logic [NUM_SRC-1:0] ack_bits,
    output logic [NUM_SRC-1:0] raw_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] raw;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            // acknowledge first, a new event then overrides it
            if (ack_stb && ack_bits[i]) st_d.raw[i] = 1'b0;
            if (event_i[i])             st_d.raw[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o = st_q.raw;

endmodule

// File: rtl/feed_irq_mask.sv
module feed_irq_mask #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_stb,
    input  logic               clr_stb,
    input  logic [NUM_SRC-1:0] wbits,
    output logic [NUM_SRC-1:0] mask_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_stb) st_d.en = st_q.en | wbits;
        if (clr_stb) st_d.en = st_q.en & ~wbits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.en;

endmodule

// File: rtl/feed_irq_rdmux.sv
module feed_irq_rdmux
    import feed_irq_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int DATA_W  = 32
) (
    input  rd_sel_t            rd_sel,
    input  logic [NUM_SRC-1:0] raw,
    input  logic [NUM_SRC-1:0] mask,
    input  logic [NUM_SRC-1:0] fifo_full,
    input  logic [NUM_SRC-1:0] fifo_empty,
    output logic [DATA_W-1:0]  rdata
);

    localparam int FIFO_W = 2 * NUM_SRC;

    logic [FIFO_W-1:0] fifo_word;

    // Full/empty pairs, channel i at bits 2i+1 / 2i
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_pack
        assign fifo_word[2*g+1] = fifo_full[g];
        assign fifo_word[2*g]   = fifo_empty[g];
    end

    always_comb begin
        rdata = '0;
        unique case (rd_sel)
            RD_RAW:  rdata[NUM_SRC-1:0] = raw;
            RD_MASK: rdata[NUM_SRC-1:0] = mask;
            RD_PEND: rdata[NUM_SRC-1:0] = raw & mask;
            RD_FIFO: rdata[FIFO_W-1:0]  = fifo_word;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/feed_irq_unit.sv
module feed_irq_unit
    import feed_irq_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] event_i,
    input  logic [NUM_SRC-1:0] fifo_full_i,
    input  logic [NUM_SRC-1:0] fifo_empty_i,
    output logic               irq_o
);

    wr_stb_t            wr_stb;
    rd_sel_t            rd_sel;
    logic [NUM_SRC-1:0] raw_w;
    logic [NUM_SRC-1:0] mask_w;

    typedef struct packed {
        logic irq;
    } top_st_t;

    top_st_t st_d, st_q;

    feed_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wr_stb   (wr_stb),
        .rd_sel   (rd_sel)
    );

    feed_irq_latch #(.NUM_SRC(NUM_SRC)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .event_i  (event_i),
        .ack_stb  (wr_stb.ack),
        .ack_bits (bus_wdata[NUM_SRC-1:0]),
        .raw_o    (raw_w)
    );

    feed_irq_mask #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_stb  (wr_stb.mask_set),
        .clr_stb  (wr_stb.mask_clr),
        .wbits    (bus_wdata[NUM_SRC-1:0]),
        .mask_o   (mask_w)
    );

    feed_irq_rdmux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rd (
        .rd_sel     (rd_sel),
        .raw        (raw_w),
        .mask       (mask_w),
        .fifo_full  (fifo_full_i),
        .fifo_empty (fifo_empty_i),
        .rdata      (bus_rdata)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(raw_w & mask_w);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

endmodule

// File: rtl/feed_irq_chk.sv
module feed_irq_chk
    import feed_irq_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_SRC-1:0] event_i,
    input logic [NUM_SRC-1:0] fifo_full_i,
    input logic [NUM_SRC-1:0] fifo_empty_i,
    input logic [NUM_SRC-1:0] raw_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic               irq_o
);

    logic wr_set, wr_clr, wr_ack, rd_mask, rd_fifo;
    assign wr_set  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_ENSET));
    assign wr_clr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_ENCLR));
    assign wr_ack  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_ACK));
    assign rd_mask = bus_sel && !bus_wr &&
                     ((bus_addr == ADDR_W'(OFS_ENSET)) || (bus_addr == ADDR_W'(OFS_ENCLR)));
    assign rd_fifo = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_FIFO));

    // R2 / R7
    event_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|event_i) |=> ((raw_q & $past(event_i)) == $past(event_i)));

    // R2
    no_spurious_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(event_i)) == '0));

    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((mask_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));

    // R4
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((mask_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));

    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> ((raw_q & $past(bus_wdata[NUM_SRC-1:0]) & ~$past(event_i)) == '0));

    // R8
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(raw_q & mask_q))));

    // R5
    mask_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mask |-> (bus_rdata == DATA_W'(mask_q)));

    // R9
    fifo_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fifo |-> (bus_rdata[1:0] == {fifo_full_i[0], fifo_empty_i[0]}));

endmodule

bind feed_irq_unit feed_irq_chk #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .event_i      (event_i),
    .fifo_full_i  (fifo_full_i),
    .fifo_empty_i (fifo_empty_i),
    .raw_q        (raw_w),
    .mask_q       (mask_w),
    .irq_o        (irq_o)
);

// File: tb/sim_feed_irq_unit.sv
`timescale 1ns/1ps
module sim_feed_irq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  event_i = '0;
    logic [3:0]  fifo_full_i = '0;
    logic [3:0]  fifo_empty_i = '0;
    logic        irq_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    feed_irq_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .event_i(event_i), .fifo_full_i(fifo_full_i), .fifo_empty_i(fifo_empty_i),
        .irq_o(irq_o)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [3:0]  ev;
        logic [7:0]  raddr;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VEC [NVEC] = '{
        '{4'd2,  1'b0, 8'h00, 32'h0000_0000, 4'h8, 8'h00, 32'h8}, // R2 masked event latches
        '{4'd5,  1'b0, 8'h00, 32'h0000_0000, 4'h1, 8'h0C, 32'h0}, // R5 pending view masked
        '{4'd3,  1'b1, 8'h04, 32'h0000_0009, 4'h0, 8'h04, 32'h9}, // R3 set bits
        '{4'd5,  1'b0, 8'h00, 32'h0000_0000, 4'h0, 8'h0C, 32'h9}, // R5 pending = raw & mask
        '{4'd4,  1'b1, 8'h08, 32'h0000_0001, 4'h0, 8'h08, 32'h8}, // R4 clear bit
        '{4'd6,  1'b1, 8'h0C, 32'h0000_0008, 4'h0, 8'h00, 32'h1}, // R6 ack one bit
        '{4'd10, 1'b1, 8'h00, 32'h0000_000F, 4'h0, 8'h00, 32'h1}, // R10 raw write ignored
        '{4'd7,  1'b1, 8'h0C, 32'h0000_0001, 4'h1, 8'h00, 32'h1}, // R7 event beats ack
        '{4'd6,  1'b1, 8'h0C, 32'h0000_0001, 4'h0, 8'h00, 32'h0}, // R6 ack clears
        '{4'd3,  1'b1, 8'h04, 32'hFFFF_FFF0, 4'h0, 8'h04, 32'h8}, // R3 upper bits ignored
        '{4'd2,  1'b0, 8'h00, 32'h0000_0000, 4'h6, 8'h00, 32'h6}, // R2 two events
        '{4'd7,  1'b1, 8'h0C, 32'h0000_0006, 4'h4, 8'h00, 32'h4}, // R7 mixed race
        '{4'd4,  1'b1, 8'h08, 32'h0000_0000, 4'h0, 8'h04, 32'h8}, // R4 zero clear no-op
        '{4'd10, 1'b1, 8'h10, 32'hFFFF_FFFF, 4'h0, 8'h14, 32'h0}  // R10 unmapped read
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // drive for one clock edge, then return to idle at the next falling edge
    task automatic drive(input logic wr, input logic [7:0] addr,
                         input logic [31:0] wdata, input logic [3:0] ev);
        bus_sel = wr; bus_wr = wr; bus_addr = addr; bus_wdata = wdata; event_i = ev;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; event_i = '0;
    endtask

    task automatic rd(input logic [7:0] addr, output logic [31:0] val);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addr;
        #1 val = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1 check("R1 irq", {31'd0, irq_o}, 32'h0);
        rd(8'h00, v); check("R1 raw", v, 32'h0);
        rd(8'h04, v); check("R1 mask", v, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i].wr, VEC[i].addr, VEC[i].wdata, VEC[i].ev);
            rd(VEC[i].raddr, v);
            check($sformatf("R%0d vec %0d", VEC[i].req, i), v, VEC[i].exp);
        end

        // now raw=4, mask=8, irq=0
        // R8 interrupt timing
        drive(1'b0, 8'h00, 32'h0, 4'h8);
        #1 check("R8 irq one cycle after raw", {31'd0, irq_o}, 32'h0);
        @(negedge clk);
        #1 check("R8 irq asserted", {31'd0, irq_o}, 32'h1);
        @(negedge clk);
        drive(1'b1, 8'h0C, 32'h8, 4'h0);
        #1 check("R8 irq holds one cycle after ack", {31'd0, irq_o}, 32'h1);
        @(negedge clk);
        #1 check("R8 irq drops", {31'd0, irq_o}, 32'h0);
        // R8 masked event does not raise irq
        drive(1'b0, 8'h00, 32'h0, 4'h1);
        @(negedge clk);
        #1 check("R8 masked event no irq", {31'd0, irq_o}, 32'h0);
        rd(8'h00, v); check("R2 raw after masked event", v, 32'h5);

        // R9 FIFO status word
        fifo_full_i = 4'b1010; fifo_empty_i = 4'b0101;
        rd(8'h10, v); check("R9 fifo mixed", v, 32'h99);
        fifo_full_i = 4'b1111; fifo_empty_i = 4'b0000;
        rd(8'h10, v); check("R9 fifo all full", v, 32'hAA);
        fifo_full_i = 4'b0000; fifo_empty_i = 4'b1000;
        rd(8'h10, v); check("R9 fifo ch3 empty", v, 32'h40);

        // R1 reset mid-run with state present
        drive(1'b1, 8'h04, 32'hF, 4'h0);
        @(negedge clk);
        #1 check("R8 irq before reset", {31'd0, irq_o}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 irq after reset", {31'd0, irq_o}, 32'h0);
        rd(8'h00, v); check("R1 raw after reset", v, 32'h0);
        rd(8'h08, v); check("R1 mask after reset", v, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule